// File: doc/BRIEF.md
# Pin Edge Interrupt Router

This block turns edges on general-purpose input pins into latched interrupt requests and one-cycle event pulses. It serves sixteen lines. Each line picks one of seven input ports through a 4-bit selector code, and the line's signal is then synchronised to the system clock. The block detects rising edges, falling edges or both, as chosen per line. A detected edge sets a sticky pending bit. Software clears that bit by writing a one to it.

A per-line interrupt mask gates the pending bits onto the request outputs. Lines 0 to 4 each have a request output of their own. Lines 5 to 9 share one request output, and lines 10 to 15 share another. A separate event mask turns each detected edge into a single-cycle pulse on a per-line event output. A software trigger register sets pending bits without any pin activity.

Software controls everything through a simple word-wide register bus. A write takes effect on the clock edge where it is sampled. A read returns its data one cycle after it is sampled and holds that data until the next read.

Top module: `pin_irq_router`

## Requirements
- R1: After a synchronous active-high reset, all control registers and pending bits are zero, and `irq_out` and `evt_out` are zero.
- R2: Line n takes its source from selector register at address 8 + n/4, in bits (n%4)*4 to (n%4)*4+3. Code p in 0..6 selects port p, which is pin `port_pins[p*16+n]`. Codes 7..15 hold the line low, and pins of ports that are not selected have no effect on the line.
- R3: With the line's bit set in the rise-enable register (address 2), a 0-to-1 change of the selected pin sets the line's pending bit. A 1-to-0 change does not set it unless falling is also enabled.
- R4: With the line's bit set in the fall-enable register (address 3), a 1-to-0 change sets the pending bit. A 0-to-1 change does not set it unless rising is also enabled.
- R5: With both enables set, every change of the selected pin sets the pending bit.
- R6: The pending register (address 5, readable) clears a bit when a 1 is written to it, and ignores bits written as 0. If an edge is detected in the same cycle as the clearing write, the bit stays set.
- R7: Writing a 1 to a bit of the software trigger register (address 4) sets that line's pending bit on the same clock edge. This register reads back as zero.
- R8: Bits 0..4 of `irq_out` carry pending AND interrupt mask (address 0) for lines 0..4. Bit 5 is the OR of that product over lines 5..9, and bit 6 is the OR over lines 10..15. Pending bits latch regardless of the mask.
- R9: `evt_out[n]` pulses high for exactly one cycle for each detected edge or software trigger on line n whose bit is set in the event mask (address 1). The pulse does not depend on the interrupt mask.
- R10: If a pin changes before clock edge k, the event pulse is high after edge k+2, and the request output rises after edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | 112 | Asynchronous pin inputs, port p line n at bit p*16+n |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| irq_out | output | 7 | Interrupt requests: five single lines, then the 5..9 group, then the 10..15 group |
| evt_out | output | 16 | One-cycle event pulse per line |

## Verification
The bench drives lines through several port routings: a valid code, a pin on a port that is not selected, and a selector code outside the valid range. This separates correct selection from a mux that ignores or misreads its code. Each edge polarity is applied both with and without its enable, so a polarity swap or a missing gate shows up as a wrong pending value. A hardware edge is timed to land on the same cycle as a clearing write, which tells set priority from clear priority. A masked line that is later unmasked separates the latch from the request gating. Single-cycle sampling around one edge pins down the pipeline depth of both the event and the request path.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  // Word addresses of the control registers
  localparam int unsigned ADR_IMASK = 0;
  localparam int unsigned ADR_EMASK = 1;
  localparam int unsigned ADR_RISE  = 2;
  localparam int unsigned ADR_FALL  = 3;
  localparam int unsigned ADR_SOFT  = 4;
  localparam int unsigned ADR_PEND  = 5;
  localparam int unsigned ADR_SEL0  = 8;
  // Selector codes packed per selector register
  localparam int unsigned SEL_PER_REG = 4;
endpackage

// File: rtl/pin_irq_srcmux.sv
module pin_irq_srcmux #(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 7,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0] pins,
  input  logic [NUM_LINES*SEL_W-1:0]     sel_flat,
  output logic [NUM_LINES-1:0]           line_raw
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [SEL_W-1:0] code;
    assign code = sel_flat[n*SEL_W +: SEL_W];
    always_comb begin
      line_raw[n] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (code == SEL_W'(p)) line_raw[n] = pins[p*NUM_LINES + n];
      end
    end
  end
endmodule

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_s,
  input  logic [NUM_LINES-1:0] rise_en,
  input  logic [NUM_LINES-1:0] fall_en,
  input  logic [NUM_LINES-1:0] soft_vec,
  input  logic [NUM_LINES-1:0] clr_vec,
  input  logic [NUM_LINES-1:0] emask,
  output logic [NUM_LINES-1:0] set_vec,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] evt_q
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] rose;
  logic [NUM_LINES-1:0] fell;

  assign rose    = line_s & ~prev_q;
  assign fell    = ~line_s & prev_q;
  assign set_vec = (rose & rise_en) | (fell & fall_en) | soft_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= line_s;
      // a fresh edge outranks a clearing write in the same cycle
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      evt_q  <= set_vec & emask;
    end
  end
endmodule

// File: rtl/pin_irq_merge.sv
module pin_irq_merge #(
  parameter int NUM_LINES = 16,
  parameter int NUM_SOLO  = 5,
  parameter int MID_COUNT = 5,
  localparam int NUM_IRQ  = NUM_SOLO + 2,
  localparam int HI_BASE  = NUM_SOLO + MID_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] imask,
  output logic [NUM_IRQ-1:0]   irq_q
);
  logic [NUM_LINES-1:0] active;
  logic [NUM_IRQ-1:0]   irq_d;

  assign active = pend & imask;

  for (genvar i = 0; i < NUM_SOLO; i++) begin : g_solo
    assign irq_d[i] = active[i];
  end
  assign irq_d[NUM_SOLO]   = |active[HI_BASE-1:NUM_SOLO];
  assign irq_d[NUM_SOLO+1] = |active[NUM_LINES-1:HI_BASE];

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router #(
  parameter int NUM_LINES   = 16,
  parameter int NUM_PORTS   = 7,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_SOLO    = 5,
  parameter int MID_COUNT   = 5,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  localparam int NUM_IRQ    = NUM_SOLO + 2,
  localparam int PER_REG    = int'(pin_irq_pkg::SEL_PER_REG),
  localparam int SEL_REG_W  = PER_REG * SEL_W,
  localparam int NUM_SEL    = (NUM_LINES + PER_REG - 1) / PER_REG,
  localparam int LOW_USED   = (SEL_REG_W > NUM_LINES) ? SEL_REG_W : NUM_LINES
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           bus_we,
  input  logic                           bus_re,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_IRQ-1:0]             irq_out,
  output logic [NUM_LINES-1:0]           evt_out
);
  import pin_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(ADR_IMASK);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(ADR_EMASK);
  localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(ADR_RISE);
  localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(ADR_FALL);
  localparam logic [ADDR_W-1:0] A_SOFT  = ADDR_W'(ADR_SOFT);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(ADR_PEND);

  logic [NUM_LINES-1:0]       imask_q, emask_q, rise_q, fall_q;
  logic [SEL_REG_W-1:0]       sel_reg [NUM_SEL];
  logic [NUM_LINES*SEL_W-1:0] sel_flat;
  logic [NUM_LINES-1:0]       line_raw, line_s;
  logic [NUM_LINES-1:0]       soft_vec, clr_vec, set_vec, pend_q;
  logic [DATA_W-1:0]          rd_val;
  logic                       unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LOW_USED];

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_IMASK) imask_q <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == A_EMASK) emask_q <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == A_RISE)  rise_q  <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == A_FALL)  fall_q  <= bus_wdata[NUM_LINES-1:0];
    end
  end

  for (genvar r = 0; r < NUM_SEL; r++) begin : g_selreg
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(ADR_SEL0 + r);
    always_ff @(posedge clk) begin
      if (rst)                               sel_reg[r] <= '0;
      else if (bus_we && bus_addr == MY_ADR) sel_reg[r] <= bus_wdata[SEL_REG_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_unpack
    assign sel_flat[n*SEL_W +: SEL_W] = sel_reg[n/PER_REG][(n%PER_REG)*SEL_W +: SEL_W];
  end

  // write strobes that act on the pending latch directly
  assign soft_vec = (bus_we && bus_addr == A_SOFT) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign clr_vec  = (bus_we && bus_addr == A_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

  // read path
  always_comb begin
    rd_val = '0;
    if (bus_addr == A_IMASK) rd_val[NUM_LINES-1:0] = imask_q;
    if (bus_addr == A_EMASK) rd_val[NUM_LINES-1:0] = emask_q;
    if (bus_addr == A_RISE)  rd_val[NUM_LINES-1:0] = rise_q;
    if (bus_addr == A_FALL)  rd_val[NUM_LINES-1:0] = fall_q;
    if (bus_addr == A_PEND)  rd_val[NUM_LINES-1:0] = pend_q;
    for (int r = 0; r < NUM_SEL; r++) begin
      if (bus_addr == ADDR_W'(ADR_SEL0 + r)) rd_val[SEL_REG_W-1:0] = sel_reg[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  pin_irq_srcmux #(
    .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)
  ) u_mux (
    .pins(port_pins), .sel_flat(sel_flat), .line_raw(line_raw)
  );

  pin_irq_sync #(
    .WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .d(line_raw), .q(line_s)
  );

  pin_irq_edge #(
    .NUM_LINES(NUM_LINES)
  ) u_edge (
    .clk(clk), .rst(rst), .line_s(line_s), .rise_en(rise_q), .fall_en(fall_q),
    .soft_vec(soft_vec), .clr_vec(clr_vec), .emask(emask_q),
    .set_vec(set_vec), .pend_q(pend_q), .evt_q(evt_out)
  );

  pin_irq_merge #(
    .NUM_LINES(NUM_LINES), .NUM_SOLO(NUM_SOLO), .MID_COUNT(MID_COUNT)
  ) u_merge (
    .clk(clk), .rst(rst), .pend(pend_q), .imask(imask_q), .irq_q(irq_out)
  );
endmodule

// File: rtl/pin_irq_router_chk.sv
module pin_irq_router_chk #(
  parameter int NUM_LINES = 16,
  parameter int NUM_SOLO  = 5,
  parameter int NUM_IRQ   = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_IRQ-1:0]   irq_out,
  input logic [NUM_LINES-1:0] evt_out,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] imask_q,
  input logic [NUM_LINES-1:0] emask_q,
  input logic [NUM_LINES-1:0] set_vec,
  input logic [NUM_LINES-1:0] clr_vec,
  input logic [NUM_LINES-1:0] soft_vec
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (irq_out == '0 && evt_out == '0)); // R1

  AST_PEND_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0); // R3

  AST_CLEAR_WINS_ALONE: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_vec & ~set_vec) & pend_q) == '0); // R6

  AST_SOFT_SETS: assert property (@(posedge clk) disable iff (rst)
    ($past(soft_vec) & ~pend_q) == '0); // R7

  AST_SOLO_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_out[NUM_SOLO-1:0] & ~$past(pend_q[NUM_SOLO-1:0] & imask_q[NUM_SOLO-1:0])) == '0); // R8

  AST_EVT_MASKED: assert property (@(posedge clk) disable iff (rst)
    (evt_out & ~$past(emask_q)) == '0); // R9
endmodule

bind pin_irq_router pin_irq_router_chk #(
  .NUM_LINES(NUM_LINES), .NUM_SOLO(NUM_SOLO), .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .evt_out(evt_out), .pend_q(pend_q),
  .imask_q(imask_q), .emask_q(emask_q), .set_vec(set_vec), .clr_vec(clr_vec),
  .soft_vec(soft_vec)
);

// File: tb/tb_pin_irq_router.sv
module tb_pin_irq_router;
  localparam int NL = 16;
  localparam int NP = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NP*NL-1:0] port_pins = '0;
  logic           bus_we = 1'b0;
  logic           bus_re = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [6:0]     irq_out;
  logic [NL-1:0]  evt_out;

  pin_irq_router dut (
    .clk(clk), .rst(rst), .port_pins(port_pins), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .evt_out(evt_out)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] rdata;
    logic [6:0]  irq;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  int evt_cnt [NL];
  initial for (int i = 0; i < NL; i++) evt_cnt[i] = 0;
  always @(negedge clk) if (!rst) for (int i = 0; i < NL; i++) if (evt_out[i]) evt_cnt[i]++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check({it.tag, " rdata"}, bus_rdata, it.rdata);
        check({it.tag, " irq"}, {25'd0, irq_out}, {25'd0, it.irq});
      end
    end
  end

  function automatic logic [6:0] f_irq(logic [15:0] p, logic [15:0] m);
    logic [15:0] a;
    a = p & m;
    return {|a[15:10], |a[9:5], a[4:0]};
  endfunction

  logic [15:0] exp_pend = '0;
  logic [15:0] im = '0;

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_expect(logic [3:0] a, logic [31:0] exp, logic [6:0] irq_exp, string tag);
    sb_item_t it;
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0;
    #1;
    it.rdata = exp; it.irq = irq_exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(int port, int line, logic v);
    @(negedge clk); port_pins[port*NL + line] = v;
  endtask

  task automatic chk_pend(string tag);
    rd_expect(4'd5, {16'd0, exp_pend}, f_irq(exp_pend, im), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {25'd0, irq_out}, 32'd0);
    check("R1 evt after reset", {16'd0, evt_out}, 32'd0);
    chk_pend("R1 pending reset");
    rd_expect(4'd0, 32'd0, 7'd0, "R1 imask reset");
    rd_expect(4'd8, 32'd0, 7'd0, "R1 selector reset");

    // selectors: line5->port C(2), line3->code 9 (none), line12->port G(6)
    wr(4'd9, 32'h0020);
    wr(4'd8, 32'h9000);
    wr(4'd11, 32'h0006);
    rd_expect(4'd9, 32'h0020, 7'd0, "R2 selector readback");
    rd_expect(4'd11, 32'h0006, 7'd0, "R2 selector readback hi");

    wr(4'd2, 32'h1009);
    wr(4'd3, 32'h1020);
    wr(4'd0, 32'h0021); im = 16'h0021;
    wr(4'd1, 32'h0011);

    // unselected port drives line 0 pin: no effect
    set_pin(1, 0, 1'b1); settle(5);
    chk_pend("R2 unselected port ignored");

    set_pin(0, 0, 1'b1); settle(5); exp_pend = 16'h0001;
    chk_pend("R3 rising edge latched");
    set_pin(0, 0, 1'b0); settle(5);
    chk_pend("R3 falling edge ignored when only rise enabled");

    wr(4'd5, 32'hFFFE);
    chk_pend("R6 zero write keeps pending");
    wr(4'd5, 32'h0001); exp_pend = 16'h0000;
    chk_pend("R6 one write clears pending");

    set_pin(2, 5, 1'b1); settle(5);
    chk_pend("R4 rising ignored when only fall enabled");
    set_pin(2, 5, 1'b0); settle(5); exp_pend = 16'h0020;
    chk_pend("R4 falling edge latched, R8 mid group request");

    set_pin(6, 12, 1'b1); settle(5); exp_pend = 16'h1020;
    chk_pend("R5 rise on both-edge line, R8 masked hi group");
    wr(4'd5, 32'h1000); exp_pend = 16'h0020;
    set_pin(6, 12, 1'b0); settle(5); exp_pend = 16'h1020;
    chk_pend("R5 fall on both-edge line");

    wr(4'd0, 32'h1021); im = 16'h1021;
    chk_pend("R8 unmasking raises hi group request");

    for (int p = 0; p < NP; p++) port_pins[p*NL + 3] = 1'b1;
    settle(5);
    chk_pend("R2 out-of-range code holds line low");
    for (int p = 0; p < NP; p++) port_pins[p*NL + 3] = 1'b0;
    settle(5);

    wr(4'd5, 32'hFFFF); exp_pend = 16'h0000;
    wr(4'd0, 32'h0031); im = 16'h0031;
    wr(4'd4, 32'h0010); exp_pend = 16'h0010;
    chk_pend("R7 software trigger sets pending");
    rd_expect(4'd4, 32'd0, f_irq(exp_pend, im), "R7 trigger reads zero");

    // collision: hardware edge lands on the clearing write
    wr(4'd4, 32'h0001); exp_pend = 16'h0011;
    @(negedge clk); port_pins[0] = 1'b1;
    @(negedge clk);
    wr(4'd5, 32'h0001);
    chk_pend("R6 edge beats simultaneous clear");
    wr(4'd5, 32'h0001); exp_pend = 16'h0010;
    chk_pend("R6 clear without edge");

    // exact latency on line 0
    set_pin(0, 0, 1'b0); settle(5);
    wr(4'd5, 32'hFFFF); exp_pend = 16'h0000;
    settle(3);
    @(negedge clk); port_pins[0] = 1'b1;
    @(negedge clk);
    check("R10 no event after one edge", {31'd0, evt_out[0]}, 32'd0);
    @(negedge clk);
    check("R10 no event after two edges", {31'd0, evt_out[0]}, 32'd0);
    check("R10 no request after two edges", {31'd0, irq_out[0]}, 32'd0);
    @(negedge clk);
    check("R10 event after three edges", {31'd0, evt_out[0]}, 32'd1);
    check("R10 no request after three edges", {31'd0, irq_out[0]}, 32'd0);
    @(negedge clk);
    check("R9 event lasts one cycle", {31'd0, evt_out[0]}, 32'd0);
    check("R10 request after four edges", {31'd0, irq_out[0]}, 32'd1);

    settle(3);
    check("R9 event count line 0", evt_cnt[0], 32'd4);
    check("R9 event count line 4 soft", evt_cnt[4], 32'd1);
    check("R9 event masked line 5", evt_cnt[5], 32'd0);
    check("R9 event masked line 12", evt_cnt[12], 32'd0);

    while (sb_q.size() != 0) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule